// File: doc/BRIEF.md
# Interrupt flag, mask and vector unit

This block collects interrupt requests for a small microcontroller core and turns them into a single request line and a program vector address. It watches one external interrupt pin, a group of general I/O pins and three timer event strobes. It holds the enable and flag state in three byte-wide registers on the core's I/O bus.

The external pin can be set to react to a low level, to any change, to a falling edge or to a rising edge. Any change on the I/O pin group raises one shared pin-change flag. Timer events are held as pending bits inside the block. A source can interrupt only when its own enable bit and the core's global interrupt bit are both set. When several sources are pending, the one with the lowest vector address is presented. An acknowledge pulse from the core, given when it enters the routine, clears the flag of the source that was presented. Software clears a flag by writing a one to it.

The timers, the CPU and the stack are outside the block. They appear only as input strobes, the global enable input and the acknowledge input.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset all three registers read 0x00 and `irq_req` is low.
- R2: The mask register at address 0x3B has writable bits 6 (external enable) and 5 (pin-change enable). The timer mask register at 0x39 has writable bits 6 (timer1 compare), 2 (timer1 overflow) and 1 (timer0 overflow). Every other bit reads 0, and any other address reads 0x00.
- R3: At flag address 0x3A (bit 6 external, bit 5 pin change), writing 1 to a flag bit clears it and writing 0 leaves it unchanged.
- R4: `ext_mode` 2'b01 sets the external flag on any pin change, 2'b10 on a falling edge and 2'b11 on a rising edge. The flag becomes visible at the third rising clock edge after the pin moves.
- R5: With `ext_mode` 2'b00 (level), the external flag is held at 0 and the external request follows a low synchronized pin directly. An acknowledge does not remove that request.
- R6: A change on any bit of `port_pins` sets the pin-change flag, with the same three-edge latency.
- R7: Flags and pending bits latch even when the source is disabled. `irq_req` is high only when `gie` is high and at least one pending source is enabled.
- R8: The vector addresses are external 0x001, pin change 0x002, timer1 compare 0x003, timer1 overflow 0x004 and timer0 overflow 0x005. `irq_vec` shows the lowest of the pending and enabled sources, and shows 0 when there is none.
- R9: An `irq_ack` while `irq_req` is high clears only the flag or pending bit of the source shown on `irq_vec`.
- R10: Timer event strobes set internal pending bits, which are gated by the timer mask bits and are cleared only by acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O register address |
| io_we | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr |
| gie | input | 1 | Global interrupt enable from the core |
| ext_mode | input | 2 | External pin sense: 00 level-low, 01 any change, 10 falling, 11 rising |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| port_pins | input | NPINS | I/O pins watched for change (asynchronous) |
| tmr1_cmp_evt | input | 1 | Timer1 compare-match strobe |
| tmr1_ovf_evt | input | 1 | Timer1 overflow strobe |
| tmr0_ovf_evt | input | 1 | Timer0 overflow strobe |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address of the selected source |
| irq_ack | input | 1 | Core entered the routine of the presented vector |

## Verification
The hardest state to reach from the ports is a specific mix of pending sources seen under every enable pattern. The external and pin-change flags can be set only through synchronized pin activity, and the timer pending bits can be removed only by acknowledge. The bench therefore builds each of the 32 pending subsets from real pin edges and timer strobes while all sources are masked. It then sweeps all 32 enable patterns with the global bit both off and on, and finally drains the subset one acknowledge at a time, checking the vector each step.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  localparam int NSRC  = 5;
  localparam int VEC_W = 9;

  // source index equals priority rank; vector = index + 1
  localparam int SRC_EXT  = 0;
  localparam int SRC_PC   = 1;
  localparam int SRC_CMP1 = 2;
  localparam int SRC_OVF1 = 3;
  localparam int SRC_OVF0 = 4;

  localparam logic [7:0] ADDR_TMASK = 8'h39;
  localparam logic [7:0] ADDR_GFLAG = 8'h3A;
  localparam logic [7:0] ADDR_GMASK = 8'h3B;

  localparam int BIT_EXT  = 6;
  localparam int BIT_PC   = 5;
  localparam int BIT_CMP1 = 6;
  localparam int BIT_OVF1 = 2;
  localparam int BIT_OVF0 = 1;

  typedef enum logic [1:0] {
    EXT_LEVEL = 2'b00,
    EXT_ANY   = 2'b01,
    EXT_FALL  = 2'b10,
    EXT_RISE  = 2'b11
  } ext_mode_e;
endpackage

// File: rtl/irqu_sync.sv
module irqu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irqu_prio.sv
module irqu_prio #(
  parameter int N     = 5,
  parameter int VEC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pend,
  output logic             any,
  output logic [N-1:0]     sel,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    any = |pend;
    sel = '0;
    vec = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        vec    = VEC_W'(i + 1);
      end
    end
  end

  a_r8_vec_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (vec != '0 && vec <= VEC_W'(N)));
  a_r8_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !any |-> (vec == '0 && sel == '0));
  a_r9_sel_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irqu_pkg::*;
#(
  parameter int NPINS  = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_we,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              gie,
  input  logic [1:0]        ext_mode,
  input  logic              ext_pin,
  input  logic [NPINS-1:0]  port_pins,
  input  logic              tmr1_cmp_evt,
  input  logic              tmr1_ovf_evt,
  input  logic              tmr0_ovf_evt,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack
);
  localparam int SW = NPINS + 1;

  // synchronized pins and their previous sample
  logic [SW-1:0] pins_s, pins_p;
  irqu_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ext_pin, port_pins}), .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_p <= '0;
    else        pins_p <= pins_s;
  end

  logic ext_now, ext_old, ext_evt, pc_evt, ext_level;
  assign ext_now   = pins_s[NPINS];
  assign ext_old   = pins_p[NPINS];
  assign pc_evt    = |(pins_s[NPINS-1:0] ^ pins_p[NPINS-1:0]);
  assign ext_level = (ext_mode_e'(ext_mode) == EXT_LEVEL);

  always_comb begin
    unique case (ext_mode_e'(ext_mode))
      EXT_ANY:  ext_evt = ext_now ^ ext_old;
      EXT_FALL: ext_evt = ext_old & ~ext_now;
      EXT_RISE: ext_evt = ~ext_old & ext_now;
      default:  ext_evt = 1'b0;
    endcase
  end

  // register file state
  logic gm_ext_q, gm_pc_q, tm_cmp_q, tm_ovf1_q, tm_ovf0_q;
  logic gm_ext_d, gm_pc_d, tm_cmp_d, tm_ovf1_d, tm_ovf0_d;
  logic fl_ext_q, fl_pc_q, tp_cmp_q, tp_ovf1_q, tp_ovf0_q;
  logic fl_ext_d, fl_pc_d, tp_cmp_d, tp_ovf1_d, tp_ovf0_d;

  logic wr_gm, wr_tm, wr_gf;
  assign wr_gm = io_we && (io_addr == ADDR_W'(ADDR_GMASK));
  assign wr_tm = io_we && (io_addr == ADDR_W'(ADDR_TMASK));
  assign wr_gf = io_we && (io_addr == ADDR_W'(ADDR_GFLAG));

  logic unused_wbits;
  assign unused_wbits = ^{io_wdata[7], io_wdata[4:3], io_wdata[0]};

  // priority selection
  logic [NSRC-1:0] pend, en, sel, ack_clr;
  logic            any;
  assign pend = {tp_ovf0_q, tp_ovf1_q, tp_cmp_q, fl_pc_q,
                 fl_ext_q | (ext_level & ~ext_now)};
  assign en   = {tm_ovf0_q, tm_ovf1_q, tm_cmp_q, gm_pc_q, gm_ext_q};

  irqu_prio #(.N(NSRC), .VEC_W(VEC_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend & en),
    .any(any), .sel(sel), .vec(irq_vec)
  );

  assign irq_req = gie & any;
  assign ack_clr = (irq_ack && irq_req) ? sel : '0;

  // next state: a new event wins over any clear in the same cycle
  always_comb begin
    gm_ext_d  = wr_gm ? io_wdata[BIT_EXT]  : gm_ext_q;
    gm_pc_d   = wr_gm ? io_wdata[BIT_PC]   : gm_pc_q;
    tm_cmp_d  = wr_tm ? io_wdata[BIT_CMP1] : tm_cmp_q;
    tm_ovf1_d = wr_tm ? io_wdata[BIT_OVF1] : tm_ovf1_q;
    tm_ovf0_d = wr_tm ? io_wdata[BIT_OVF0] : tm_ovf0_q;

    fl_ext_d = ext_evt |
               (fl_ext_q & ~(wr_gf & io_wdata[BIT_EXT]) & ~ack_clr[SRC_EXT]);
    if (ext_level) fl_ext_d = 1'b0;
    fl_pc_d  = pc_evt |
               (fl_pc_q & ~(wr_gf & io_wdata[BIT_PC]) & ~ack_clr[SRC_PC]);

    tp_cmp_d  = tmr1_cmp_evt | (tp_cmp_q  & ~ack_clr[SRC_CMP1]);
    tp_ovf1_d = tmr1_ovf_evt | (tp_ovf1_q & ~ack_clr[SRC_OVF1]);
    tp_ovf0_d = tmr0_ovf_evt | (tp_ovf0_q & ~ack_clr[SRC_OVF0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gm_ext_q  <= 1'b0;
      gm_pc_q   <= 1'b0;
      tm_cmp_q  <= 1'b0;
      tm_ovf1_q <= 1'b0;
      tm_ovf0_q <= 1'b0;
      fl_ext_q  <= 1'b0;
      fl_pc_q   <= 1'b0;
      tp_cmp_q  <= 1'b0;
      tp_ovf1_q <= 1'b0;
      tp_ovf0_q <= 1'b0;
    end else begin
      gm_ext_q  <= gm_ext_d;
      gm_pc_q   <= gm_pc_d;
      tm_cmp_q  <= tm_cmp_d;
      tm_ovf1_q <= tm_ovf1_d;
      tm_ovf0_q <= tm_ovf0_d;
      fl_ext_q  <= fl_ext_d;
      fl_pc_q   <= fl_pc_d;
      tp_cmp_q  <= tp_cmp_d;
      tp_ovf1_q <= tp_ovf1_d;
      tp_ovf0_q <= tp_ovf0_d;
    end
  end

  // read mux
  always_comb begin
    io_rdata = 8'h00;
    if (io_addr == ADDR_W'(ADDR_GMASK)) begin
      io_rdata[BIT_EXT] = gm_ext_q;
      io_rdata[BIT_PC]  = gm_pc_q;
    end else if (io_addr == ADDR_W'(ADDR_GFLAG)) begin
      io_rdata[BIT_EXT] = fl_ext_q;
      io_rdata[BIT_PC]  = fl_pc_q;
    end else if (io_addr == ADDR_W'(ADDR_TMASK)) begin
      io_rdata[BIT_CMP1] = tm_cmp_q;
      io_rdata[BIT_OVF1] = tm_ovf1_q;
      io_rdata[BIT_OVF0] = tm_ovf0_q;
    end
  end

  a_r5_level_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode == 2'b00) |=> !fl_ext_q);
  a_r4_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> fl_ext_q);
  a_r6_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pc_evt |=> fl_pc_q);
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gf && io_wdata[BIT_PC] && !pc_evt) |=> !fl_pc_q);
  a_r9_ack_clears_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_vec == VEC_W'(1) && !ext_evt) |=> !fl_ext_q);
  a_r7_no_req_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq_req);
endmodule

// File: tb/test_irq_flag_unit.sv
module test_irq_flag_unit;
  localparam int NPINS = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] io_addr;
  logic io_we;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic gie;
  logic [1:0] ext_mode;
  logic ext_pin;
  logic [NPINS-1:0] port_pins;
  logic tmr1_cmp_evt, tmr1_ovf_evt, tmr0_ovf_evt;
  logic irq_req;
  logic [8:0] irq_vec;
  logic irq_ack;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_flag_unit #(.NPINS(NPINS), .ADDR_W(6)) i_irq_flag_unit (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .gie(gie),
    .ext_mode(ext_mode), .ext_pin(ext_pin), .port_pins(port_pins),
    .tmr1_cmp_evt(tmr1_cmp_evt), .tmr1_ovf_evt(tmr1_ovf_evt),
    .tmr0_ovf_evt(tmr0_ovf_evt), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    @(negedge clk);
    io_we = 1'b0; io_wdata = 8'h00;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1;
  endtask

  function automatic int lowest(input logic [4:0] m);
    for (int i = 4; i >= 0; i--) if (m[i]) lowest = i + 1;
    if (m == 5'd0) lowest = 0;
  endfunction

  // enable bits: 0 ext, 1 pc, 2 cmp1, 3 ovf1, 4 ovf0
  task automatic set_en(input logic [4:0] e);
    wr(6'h3B, {1'b0, e[0], e[1], 5'b0});
    wr(6'h39, {1'b0, e[2], 3'b0, e[3], e[4], 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; io_addr = '0; io_we = 1'b0; io_wdata = '0; gie = 1'b0;
    ext_mode = 2'b11; ext_pin = 1'b0; port_pins = '0; irq_ack = 1'b0;
    tmr1_cmp_evt = 1'b0; tmr1_ovf_evt = 1'b0; tmr0_ovf_evt = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(6'h3B, v); check("R1 gmask", v, 8'h00);
    rd(6'h3A, v); check("R1 gflag", v, 8'h00);
    rd(6'h39, v); check("R1 tmask", v, 8'h00);
    check("R1 irq_req", irq_req, 1'b0);

    // R2 exhaustive write/readback of both mask registers
    for (int d = 0; d < 256; d++) begin
      wr(6'h3B, 8'(d)); rd(6'h3B, v); check("R2 gmask", v, 8'(d) & 8'h60);
      wr(6'h39, 8'(d)); rd(6'h39, v); check("R2 tmask", v, 8'(d) & 8'h46);
    end
    for (int a = 0; a < 64; a++) begin
      if (a != 'h39 && a != 'h3A && a != 'h3B) begin
        wr(6'(a), 8'hFF); rd(6'(a), v); check("R2 unmapped", v, 8'h00);
      end
    end
    wr(6'h39, 8'h00); wr(6'h3B, 8'h00);
    rd(6'h3A, v); check("R2 flags untouched", v, 8'h00);

    // R4 edge modes, both directions, with latency check
    for (int m = 1; m < 4; m++) begin
      for (int dir = 0; dir < 2; dir++) begin
        ext_mode = 2'(m);
        ext_pin = (dir == 0) ? 1'b0 : 1'b1;
        step(4);
        wr(6'h3A, 8'h40);
        ext_pin = ~ext_pin;
        step(2);
        rd(6'h3A, v); check("R4 latency not yet", v[6], 1'b0);
        step(1);
        rd(6'h3A, v);
        check("R4 edge mode", v[6],
              (m == 1) || (m == 3 && dir == 0) || (m == 2 && dir == 1));
      end
    end
    ext_mode = 2'b11; ext_pin = 1'b0; step(4);

    // R3 write-one-to-clear and write-zero-keeps
    ext_pin = 1'b1; port_pins[1] = 1'b1; step(4);
    rd(6'h3A, v); check("R3 both set", v, 8'h60);
    wr(6'h3A, 8'h9F); rd(6'h3A, v); check("R3 write zero keeps", v, 8'h60);
    wr(6'h3A, 8'h20); rd(6'h3A, v); check("R3 clear pc only", v, 8'h40);
    wr(6'h3A, 8'h40); rd(6'h3A, v); check("R3 clear ext", v, 8'h00);
    ext_pin = 1'b0; step(4);

    // R6 each pin bit, both directions
    for (int b = 0; b < NPINS; b++) begin
      for (int k = 0; k < 2; k++) begin
        wr(6'h3A, 8'h20);
        port_pins[b] = ~port_pins[b];
        step(3);
        rd(6'h3A, v); check("R6 pin change", v[5], 1'b1);
      end
    end
    wr(6'h3A, 8'h20);
    rd(6'h3A, v); check("R6 cleared", v[5], 1'b0);

    // R5 level mode
    ext_mode = 2'b01; ext_pin = 1'b1; step(3);
    rd(6'h3A, v); check("R5 flag before level", v[6], 1'b1);
    ext_mode = 2'b00; step(1);
    rd(6'h3A, v); check("R5 level forces flag clear", v[6], 1'b0);
    wr(6'h3B, 8'h40); gie = 1'b1; step(2);
    check("R5 high pin no req", irq_req, 1'b0);
    ext_pin = 1'b0; step(1);
    check("R5 one edge not yet", irq_req, 1'b0);
    step(1);
    check("R5 low pin req", irq_req, 1'b1);
    check("R8 ext vector", irq_vec, 9'h001);
    rd(6'h3A, v); check("R5 flag stays zero", v[6], 1'b0);
    ack_pulse();
    check("R5 ack keeps level req", irq_req, 1'b1);
    ext_pin = 1'b1; step(2);
    check("R5 release", irq_req, 1'b0);
    gie = 1'b0; wr(6'h3B, 8'h00);
    ext_mode = 2'b11; ext_pin = 1'b0; step(4);

    // R7 R8 R9 R10 exhaustive pending subsets x enables x gie
    for (int s = 0; s < 32; s++) begin
      if (s[0]) begin
        ext_pin = 1'b1; step(3); ext_pin = 1'b0; step(3);
      end
      if (s[1]) begin
        port_pins[0] = ~port_pins[0]; step(3);
      end
      tmr1_cmp_evt = s[2]; tmr1_ovf_evt = s[3]; tmr0_ovf_evt = s[4];
      step(1);
      tmr1_cmp_evt = 1'b0; tmr1_ovf_evt = 1'b0; tmr0_ovf_evt = 1'b0;
      step(1);
      rd(6'h3A, v); check("R7 flags latch while masked", v, {1'b0, s[0], s[1], 5'b0});
      for (int e = 0; e < 32; e++) begin
        set_en(5'(e));
        for (int g = 0; g < 2; g++) begin
          gie = g[0];
          #1;
          check("R7 request gating", irq_req, (g == 1) && ((s & e) != 0));
          check("R8 vector", irq_vec, 9'(lowest(5'(s & e))));
        end
      end
      set_en(5'h1F); gie = 1'b1;
      begin
        logic [4:0] rem;
        rem = 5'(s);
        for (int k = 0; k < 5; k++) begin
          if (rem != 0) begin
            check("R10 R8 drain vector", irq_vec, 9'(lowest(rem)));
            ack_pulse();
            rem[lowest(rem) - 1] = 1'b0;
            rd(6'h3A, v);
            check("R9 only served cleared", v, {1'b0, rem[0], rem[1], 5'b0});
          end
        end
        check("R9 drained", irq_req, 1'b0);
      end
      gie = 1'b0; set_en(5'h00);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule